// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block is the interrupt arbiter for a single serial channel of a UART. It takes condition inputs from the neighbouring logic: the line status error flags, the receive FIFO levels, the transmitter's holding-register-empty strobe, the modem status delta summary, an Xoff or special-character match strobe, and the two flow-control pins. Each source is gated by its own enable bit. The arbiter then picks the single highest-ranked pending source and publishes its code in an 8-bit read-only identification value. A registered interrupt line is raised whenever any enabled source is pending.

There are three event-type sources: transmit ready, character match, and a rising flow-control pin. Each one is captured in its own sticky flag. Such a flag is cleared when the CPU reads the identification value and finds that source's code there. A transmit data write also clears the transmit-ready flag. The other sources are levels, and their owners clear them.

While the CPU holds the read strobe, the identification value is frozen. Events that arrive during the read are still captured, and they appear once the strobe drops.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `ident_o` is 0x01 and `irq_o` is 0.
- R2: Sources are ranked, highest first: line status (code 0x06), receive time-out (0x0C), receive data ready (0x04), transmit ready (0x02), modem status (0x00), character match (0x10), flow pin rise (0x20). `ident_o[5:0]` shows the code of the highest-ranked enabled pending source.
- R3: With no enabled source pending, `ident_o[5:0]` is 0x01. Bit 0 is 0 exactly when a source is pending.
- R4: `ident_o[7:6]` is 2'b11 when `fifo_en_i` is 1 and 2'b00 when it is 0.
- R5: Each source is seen only while its enable is 1. `en_rx_i` covers both receive data ready and receive time-out. The time-out source additionally needs `fifo_en_i` = 1.
- R6: The line status source is pending while any bit of `ls_flags_i` (break, framing, parity, overrun) is 1. It drops once all four bits are 0.
- R7: A low-to-high transition on either bit of `flow_pins_i` raises the flow source. A falling transition raises nothing.
- R8: While `ident_rd_i` is 1, `ident_o` holds the value it had when the strobe rose. Conditions arriving meanwhile are captured, and `ident_o` shows them after the strobe falls.
- R9: When `ident_rd_i` falls, the sticky flag whose code (0x02, 0x10 or 0x20) was shown during the read is cleared, and no other flag is touched. A pulse on `thr_wr_i` clears the transmit-ready flag.
- R10: `irq_o` is a registered copy of "any enabled source pending". A level or sticky flag change shows on it after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_en_i | input | 1 | FIFO mode is on |
| en_ls_i | input | 1 | Line status interrupt enable |
| en_rx_i | input | 1 | Receive data / time-out interrupt enable |
| en_thr_i | input | 1 | Transmit ready interrupt enable |
| en_ms_i | input | 1 | Modem status interrupt enable |
| en_xoff_i | input | 1 | Character match interrupt enable |
| en_flow_i | input | 1 | Flow pin rise interrupt enable |
| ls_flags_i | input | 4 | Break, framing, parity and overrun flags |
| rx_tmo_i | input | 1 | Receive time-out level |
| rx_avail_i | input | 1 | Receive data available level |
| thr_empty_stb_i | input | 1 | One-cycle transmit-ready event |
| thr_wr_i | input | 1 | One-cycle transmit data write |
| ms_delta_i | input | 1 | Modem status change summary level |
| xoff_hit_stb_i | input | 1 | One-cycle character match event |
| flow_pins_i | input | 2 | Flow-control pins (RTS, CTS) |
| ident_rd_i | input | 1 | Identification read in progress |
| ident_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default widths: four line status flags and two flow pins. That configuration is small enough to sweep all 128 combinations of the seven sources against all 64 enable patterns, with FIFO mode alternating and a different line status flag and flow pin used in different passes. Every ranking, every masking, and the FIFO-mode dependency of the time-out source are therefore compared with an arithmetic reference. Directed sequences cover the read freeze, the selective clearing of sticky flags, the transmit write clear and the falling-edge case of the flow pins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC       = 7;
    localparam int SRC_LS     = 0;
    localparam int SRC_TMO    = 1;
    localparam int SRC_RDA    = 2;
    localparam int SRC_THR    = 3;
    localparam int SRC_MS     = 4;
    localparam int SRC_XOFF   = 5;
    localparam int SRC_FLOW   = 6;

    localparam int NEV        = 3;
    localparam int EV_THR     = 0;
    localparam int EV_XOFF    = 1;
    localparam int EV_FLOW    = 2;

    localparam int CODE_W     = 6;
    localparam int IDENT_W    = 8;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'h01;
    localparam logic [CODE_W-1:0] CODE_LS   = 6'h06;
    localparam logic [CODE_W-1:0] CODE_TMO  = 6'h0C;
    localparam logic [CODE_W-1:0] CODE_RDA  = 6'h04;
    localparam logic [CODE_W-1:0] CODE_THR  = 6'h02;
    localparam logic [CODE_W-1:0] CODE_MS   = 6'h00;
    localparam logic [CODE_W-1:0] CODE_XOFF = 6'h10;
    localparam logic [CODE_W-1:0] CODE_FLOW = 6'h20;

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            SRC_LS:   return CODE_LS;
            SRC_TMO:  return CODE_TMO;
            SRC_RDA:  return CODE_RDA;
            SRC_THR:  return CODE_THR;
            SRC_MS:   return CODE_MS;
            SRC_XOFF: return CODE_XOFF;
            SRC_FLOW: return CODE_FLOW;
            default:  return CODE_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic               rd;
        logic [IDENT_W-1:0] ident;
        logic               irq;
    } ident_state_t;

endpackage

// File: rtl/uart_irq_rise.sv
module uart_irq_rise #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] rise_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic prev_d, prev_q;

        always_comb begin
            prev_d    = in_i[g];
            rise_o[g] = in_i[g] & ~prev_q;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/uart_irq_evflag.sv
module uart_irq_evflag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        // a new event in the same cycle as a clear survives
        pend_d = set_i | (pend_q & ~clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      req_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);
    always_comb begin
        code_o = CODE_NONE;
        // scan from lowest rank upward so the highest rank writes last
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = src_code(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LS_FLAGS = 4,
    parameter int FLOW_W   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                fifo_en_i,
    input  logic                en_ls_i,
    input  logic                en_rx_i,
    input  logic                en_thr_i,
    input  logic                en_ms_i,
    input  logic                en_xoff_i,
    input  logic                en_flow_i,
    input  logic [LS_FLAGS-1:0] ls_flags_i,
    input  logic                rx_tmo_i,
    input  logic                rx_avail_i,
    input  logic                thr_empty_stb_i,
    input  logic                thr_wr_i,
    input  logic                ms_delta_i,
    input  logic                xoff_hit_stb_i,
    input  logic [FLOW_W-1:0]   flow_pins_i,
    input  logic                ident_rd_i,
    output logic [IDENT_W-1:0]  ident_o,
    output logic                irq_o
);
    localparam int FIFO_BITS = IDENT_W - CODE_W;

    ident_state_t st_d, st_q;

    logic [FLOW_W-1:0] flow_rise;
    logic [NEV-1:0]    ev_set, ev_clr, ev_pend;
    logic [NSRC-1:0]   req;
    logic [CODE_W-1:0] win_code;
    logic              win_any;
    logic              rd_fall;

    uart_irq_rise #(.W(FLOW_W)) u_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (flow_pins_i),
        .rise_o (flow_rise)
    );

    always_comb begin
        rd_fall          = st_q.rd & ~ident_rd_i;
        ev_set[EV_THR]   = thr_empty_stb_i;
        ev_set[EV_XOFF]  = xoff_hit_stb_i;
        ev_set[EV_FLOW]  = |flow_rise;
        ev_clr[EV_THR]   = thr_wr_i | (rd_fall && st_q.ident[CODE_W-1:0] == CODE_THR);
        ev_clr[EV_XOFF]  = rd_fall && st_q.ident[CODE_W-1:0] == CODE_XOFF;
        ev_clr[EV_FLOW]  = rd_fall && st_q.ident[CODE_W-1:0] == CODE_FLOW;
    end

    for (genvar e = 0; e < NEV; e++) begin : g_ev
        uart_irq_evflag u_flag (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (ev_set[e]),
            .clr_i  (ev_clr[e]),
            .pend_o (ev_pend[e])
        );
    end

    always_comb begin
        req           = '0;
        req[SRC_LS]   = en_ls_i   & (|ls_flags_i);
        req[SRC_TMO]  = en_rx_i   & fifo_en_i & rx_tmo_i;
        req[SRC_RDA]  = en_rx_i   & rx_avail_i;
        req[SRC_THR]  = en_thr_i  & ev_pend[EV_THR];
        req[SRC_MS]   = en_ms_i   & ms_delta_i;
        req[SRC_XOFF] = en_xoff_i & ev_pend[EV_XOFF];
        req[SRC_FLOW] = en_flow_i & ev_pend[EV_FLOW];
    end

    uart_irq_prio #(.N(NSRC)) u_prio (
        .req_i  (req),
        .code_o (win_code),
        .any_o  (win_any)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rd    = ident_rd_i;
        st_d.irq   = win_any;
        if (!ident_rd_i) begin
            st_d.ident = {{FIFO_BITS{fifo_en_i}}, win_code};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.rd    <= 1'b0;
            st_q.ident <= {{FIFO_BITS{1'b0}}, CODE_NONE};
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ident_o = st_q.ident;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int LS_FLAGS = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                en_ls_i,
    input logic [LS_FLAGS-1:0] ls_flags_i,
    input logic                ident_rd_i,
    input logic [7:0]          ident_o,
    input logic                irq_o
);
    AST_PEND_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ident_rd_i) |-> (ident_o[0] == !irq_o)); // R3

    AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ident_rd_i) |-> $stable(ident_o)); // R8

    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ident_o[5:0] inside {6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20, 6'h01}); // R2

    AST_FIFO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ident_o[7] == ident_o[6]); // R4

    AST_LS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_ls_i && (|ls_flags_i) && !ident_rd_i) |-> ident_o[5:0] == 6'h06); // R6

    AST_NONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ident_o[0] |-> ident_o[5:1] == 5'd0); // R3
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LS_FLAGS(LS_FLAGS)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_ls_i    (en_ls_i),
    .ls_flags_i (ls_flags_i),
    .ident_rd_i (ident_rd_i),
    .ident_o    (ident_o),
    .irq_o      (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_ni, fifo_en_i;
    logic       en_ls_i, en_rx_i, en_thr_i, en_ms_i, en_xoff_i, en_flow_i;
    logic [3:0] ls_flags_i;
    logic       rx_tmo_i, rx_avail_i, thr_empty_stb_i, thr_wr_i, ms_delta_i, xoff_hit_stb_i;
    logic [1:0] flow_pins_i;
    logic       ident_rd_i;
    logic [7:0] ident_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    uart_irq_ident u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
        .en_ls_i(en_ls_i), .en_rx_i(en_rx_i), .en_thr_i(en_thr_i),
        .en_ms_i(en_ms_i), .en_xoff_i(en_xoff_i), .en_flow_i(en_flow_i),
        .ls_flags_i(ls_flags_i), .rx_tmo_i(rx_tmo_i), .rx_avail_i(rx_avail_i),
        .thr_empty_stb_i(thr_empty_stb_i), .thr_wr_i(thr_wr_i),
        .ms_delta_i(ms_delta_i), .xoff_hit_stb_i(xoff_hit_stb_i),
        .flow_pins_i(flow_pins_i), .ident_rd_i(ident_rd_i),
        .ident_o(ident_o), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        fifo_en_i = 0; en_ls_i = 0; en_rx_i = 0; en_thr_i = 0; en_ms_i = 0;
        en_xoff_i = 0; en_flow_i = 0; ls_flags_i = 0; rx_tmo_i = 0; rx_avail_i = 0;
        thr_empty_stb_i = 0; thr_wr_i = 0; ms_delta_i = 0; xoff_hit_stb_i = 0;
        flow_pins_i = 0; ident_rd_i = 0;
    endtask

    task automatic do_reset();
        quiet_inputs();
        rst_ni = 0;
        tick(2);
        rst_ni = 1;
    endtask

    task automatic read_pulse();
        ident_rd_i = 1;
        tick(2);
        ident_rd_i = 0;
        tick(2);
    endtask

    // reference: rank order and codes from R2, enables and FIFO rule from R5
    function automatic logic [6:0] eff_req(input logic [6:0] src, input logic [5:0] en, input logic fifo);
        logic [6:0] r;
        r[0] = src[0] & en[0];
        r[1] = src[1] & en[1] & fifo;
        r[2] = src[2] & en[1];
        r[3] = src[3] & en[2];
        r[4] = src[4] & en[3];
        r[5] = src[5] & en[4];
        r[6] = src[6] & en[5];
        return r;
    endfunction

    function automatic logic [7:0] exp_ident(input logic [6:0] r, input logic fifo);
        logic [5:0] c;
        if      (r[0]) c = 6'h06;
        else if (r[1]) c = 6'h0C;
        else if (r[2]) c = 6'h04;
        else if (r[3]) c = 6'h02;
        else if (r[4]) c = 6'h00;
        else if (r[5]) c = 6'h10;
        else if (r[6]) c = 6'h20;
        else           c = 6'h01;
        return {fifo ? 2'b11 : 2'b00, c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        tick(1);
        check("R1 reset ident", ident_o, 8'h01);
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);

        // near-exhaustive sweep: every source set against every enable set
        for (int s = 0; s < 128; s++) begin
            for (int e = 0; e < 64; e++) begin
                logic [6:0] src;
                logic [5:0] en;
                logic       fifo;
                logic [6:0] r;
                src  = 7'(s);
                en   = 6'(e);
                fifo = 1'((s + e) & 1);
                do_reset();
                check("R3 idle after reset", ident_o, 8'h01);
                fifo_en_i = fifo;
                en_ls_i = en[0]; en_rx_i = en[1]; en_thr_i = en[2];
                en_ms_i = en[3]; en_xoff_i = en[4]; en_flow_i = en[5];
                ls_flags_i = src[0] ? 4'(1 << ((s >> 1) % 4)) : 4'd0;
                rx_tmo_i = src[1]; rx_avail_i = src[2]; ms_delta_i = src[4];
                thr_empty_stb_i = src[3]; xoff_hit_stb_i = src[5];
                flow_pins_i = src[6] ? ((e & 1) ? 2'b10 : 2'b01) : 2'b00;
                tick(1);
                thr_empty_stb_i = 0; xoff_hit_stb_i = 0;
                tick(2);
                r = eff_req(src, en, fifo);
                check("R2 R4 R5 sweep ident", ident_o, exp_ident(r, fifo));
                check("R10 sweep irq", {7'd0, irq_o}, {7'd0, |r});
            end
        end

        // R8: freeze during read, event captured meanwhile
        do_reset();
        en_ls_i = 1;
        ident_rd_i = 1;
        tick(1);
        ls_flags_i = 4'b0100;
        tick(3);
        check("R8 frozen during read", ident_o, 8'h01);
        check("R8 event captured irq", {7'd0, irq_o}, 8'h01);
        ident_rd_i = 0;
        tick(2);
        check("R8 shown after read", ident_o, 8'h06);
        // R6 / R10: flags cleared -> source gone after one edge
        ls_flags_i = 0;
        tick(1);
        check("R6 line status gone", ident_o, 8'h01);
        check("R10 irq drops in one clock", {7'd0, irq_o}, 8'h00);

        // R9: read returning transmit code clears it
        do_reset();
        en_thr_i = 1;
        thr_empty_stb_i = 1; tick(1); thr_empty_stb_i = 0; tick(2);
        check("R9 thr shown", ident_o, 8'h02);
        read_pulse();
        check("R9 thr cleared by read", ident_o, 8'h01);
        check("R9 irq off after read", {7'd0, irq_o}, 8'h00);

        // R9: only the shown flag clears
        do_reset();
        en_thr_i = 1; en_xoff_i = 1;
        thr_empty_stb_i = 1; xoff_hit_stb_i = 1; tick(1);
        thr_empty_stb_i = 0; xoff_hit_stb_i = 0; tick(2);
        check("R9 thr above match", ident_o, 8'h02);
        read_pulse();
        check("R9 match survives", ident_o, 8'h10);
        read_pulse();
        check("R9 match cleared", ident_o, 8'h01);

        // R9: transmit write clears transmit flag
        do_reset();
        en_thr_i = 1;
        thr_empty_stb_i = 1; tick(1); thr_empty_stb_i = 0; tick(2);
        thr_wr_i = 1; tick(1); thr_wr_i = 0; tick(2);
        check("R9 thr cleared by write", ident_o, 8'h01);

        // R7: rising only
        do_reset();
        en_flow_i = 1; fifo_en_i = 1;
        flow_pins_i = 2'b01; tick(3);
        check("R7 rts rise", ident_o, 8'hE0);
        read_pulse();
        check("R7 flow cleared", ident_o, 8'hC1);
        flow_pins_i = 2'b00; tick(3);
        check("R7 fall ignored", ident_o, 8'hC1);
        check("R7 fall irq", {7'd0, irq_o}, 8'h00);
        flow_pins_i = 2'b10; tick(3);
        check("R7 cts rise", ident_o, 8'hE0);

        // R5: time-out needs FIFO mode
        do_reset();
        en_rx_i = 1; rx_tmo_i = 1; tick(2);
        check("R5 timeout masked without fifo", ident_o, 8'h01);
        fifo_en_i = 1; tick(2);
        check("R5 timeout with fifo", ident_o, 8'hCC);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule